// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter with two count sources. It either counts a one-cycle internal tick at instruction rate, or counts rising edges of an external clock pin. The pin edges can pass a two-stage synchronizer before counting, or take a shorter one-stage path. The shorter path keeps counting while the core is halted. A 2-bit prescale select divides the chosen source by 1, 2, 4 or 8 before the counter. A gate can pause counting. The gate comes either from a gate pin or from a comparator output. When sync is selected, the comparator output is re-timed so that it cannot change while the timer clock is high.

Software can load the count through a parallel load port. Wrapping from FFFFh to 0000h sets a sticky overflow flag, which stays set until a one-cycle clear input is pulsed. Everything runs on one system clock. The external pin is oversampled by that clock, so it must stay high and low for at least three system clocks each.

Top module: `gated_timer16`

## Requirements
- R1: After reset, `count` is 0000h and `ovf` is 0.
- R2: With `ext_sel`=0, `run_en`=1, `psel`=00 and the gate open, `count` increases by one at each clock edge where `tick_en` is 1.
- R3: With `ext_sel`=1, each rising edge of `ext_clk` adds one. With `sync_en`=0 the count changes at the 2nd clock edge after the pin rises. With `sync_en`=1 it changes at the 3rd edge.
- R4: While `core_halt`=1, internal ticks and synchronized pin edges are not counted. Unsynchronized pin edges are still counted.
- R5: `psel` values 0, 1, 2 and 3 divide the selected source by 1, 2, 4 and 8.
- R6: With `gate_en`=1 and `gate_src`=0, counting pauses while `gate_pin` is 1 and runs while it is 0 (active-low by default).
- R7: With `gate_en`=1, `gate_src`=1 and `sync_en`=1, the comparator gate is sampled only while the timer clock is low. A comparator change during a run of ticks does not stop that run. With `sync_en`=0 the comparator gates directly.
- R8: While `run_en`=0, `count` holds its value.
- R9: `load`=1 writes `load_val` into `count` at the next edge. This overrides any increment in the same cycle and clears the prescaler.
- R10: An increment from FFFFh to 0000h sets `ovf`. `ovf` stays set until `ovf_clr`=1. If a wrap and a clear happen in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal instruction-rate tick |
| core_halt | input | 1 | Core halted; stops internal and synchronized counting |
| ext_clk | input | 1 | External clock pin |
| ext_sel | input | 1 | 0 = internal tick, 1 = external pin edges |
| sync_en | input | 1 | 1 = synchronize the pin and re-time the comparator gate |
| run_en | input | 1 | Counter enable |
| psel | input | 2 | Prescale select (divide by 2^psel) |
| gate_en | input | 1 | Enable gating |
| gate_src | input | 1 | 0 = gate pin, 1 = comparator output |
| gate_pin | input | 1 | Gate pin |
| cmp_out | input | 1 | Comparator output |
| load | input | 1 | Parallel load strobe |
| load_val | input | 16 | Value to load |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| count | output | 16 | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The prescaler is hidden, and a stale phase in it shows up as a count one step early or late. The bench makes this visible by counting exact tick batches right after a load. A wrong synchronizer depth shows as a count that moves one clock earlier or later than the 2nd or 3rd edge after the pin rises, so the bench samples on exactly those edges. A comparator latch that follows its input too freely drops increments at once in a tick run, while the comparator rises. A lost overflow bit shows only at the next wrap, or after a clear, so both sides of the wrap are probed.

// File: rtl/gated_timer16.sv
module gated_timer16 #(
  parameter int W        = 16,
  parameter int PSEL_W   = 2,
  parameter bit GATE_ACT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              core_halt,
  input  logic              ext_clk,
  input  logic              ext_sel,
  input  logic              sync_en,
  input  logic              run_en,
  input  logic [PSEL_W-1:0] psel,
  input  logic              gate_en,
  input  logic              gate_src,
  input  logic              gate_pin,
  input  logic              cmp_out,
  input  logic              load,
  input  logic [W-1:0]      load_val,
  input  logic              ovf_clr,
  output logic [W-1:0]      count,
  output logic              ovf
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic [2:0]       ext_q;
  logic [PRE_W-1:0] pre;
  logic             cmp_lat;

  logic edge_async, edge_sync, raw_tick, tclk_lvl;
  logic gate_sig, gate_open, adv;
  logic [PRE_W-1:0] pre_mask;
  logic pre_hit, inc;

  assign edge_async = ext_q[0] & ~ext_q[1];
  assign edge_sync  = ext_q[1] & ~ext_q[2];

  always_comb begin
    if (!ext_sel)     raw_tick = tick_en & ~core_halt;
    else if (sync_en) raw_tick = edge_sync & ~core_halt;
    else              raw_tick = edge_async;
  end

  assign tclk_lvl  = ext_sel ? (sync_en ? ext_q[1] : ext_q[0]) : tick_en;
  assign gate_sig  = gate_src ? (sync_en ? cmp_lat : cmp_out) : gate_pin;
  assign gate_open = !gate_en || (gate_sig == GATE_ACT);
  assign adv       = raw_tick && run_en && gate_open;

  assign pre_mask = {PRE_W{1'b1}} >> (PRE_W - int'(psel));
  assign pre_hit  = (pre & pre_mask) == pre_mask;
  assign inc      = adv && pre_hit && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= '0;
      cmp_lat <= 1'b0;
      pre     <= '0;
      count   <= '0;
      ovf     <= 1'b0;
    end else begin
      ext_q <= {ext_q[1:0], ext_clk};
      if (!tclk_lvl) cmp_lat <= cmp_out;
      if (load)     pre <= '0;
      else if (adv) pre <= pre + 1'b1;
      if (load)     count <= load_val;
      else if (inc) count <= count + 1'b1;
      if (inc && count == {W{1'b1}}) ovf <= 1'b1;
      else if (ovf_clr)              ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/gated_timer16_chk.sv
module gated_timer16_chk #(
  parameter int W        = 16,
  parameter bit GATE_ACT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         gate_en,
  input logic         gate_src,
  input logic         gate_pin,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic         ovf_clr,
  input logic [W-1:0] count,
  input logic         ovf
);
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count == $past(count) || count == $past(count) + 1'b1));
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load) |=> $stable(count));
  // R6
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_src && gate_pin != GATE_ACT && !load) |=> $stable(count));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == {W{1'b1}}) |=> (count == {W{1'b1}} || ovf));
endmodule

bind gated_timer16 gated_timer16_chk #(.W(W), .GATE_ACT(GATE_ACT)) u_chk (.*);

// File: tb/tb_gated_timer16.sv
module tb_gated_timer16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, core_halt = 0, ext_clk = 0, ext_sel = 0, sync_en = 0;
  logic run_en = 1, gate_en = 0, gate_src = 0, gate_pin = 0, cmp_out = 0;
  logic load = 0, ovf_clr = 0;
  logic [1:0]  psel = 0;
  logic [15:0] load_val = 0;
  logic [15:0] count;
  logic        ovf;
  int vectors = 0, errs = 0;

  always #2.5 clk = ~clk;

  gated_timer16 dut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [15:0] v);
    load = 1; load_val = v; step(1); load = 0;
  endtask

  task automatic ticks(int n);
    tick_en = 1; step(n); tick_en = 0;
  endtask

  task automatic pulse_ext(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1; step(3); ext_clk = 0; step(3);
    end
    step(3);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'h0);
    chk("R1 ovf", {15'b0, ovf}, 16'h0);
  endtask

  task automatic t_timer;
    do_load(16'h0010); ticks(10);
    chk("R2 timer ticks", count, 16'h001a);
    step(4);
    chk("R2 idle hold", count, 16'h001a);
  endtask

  task automatic t_prescale;
    for (int p = 1; p < 4; p++) begin
      psel = 2'(p); do_load(16'h0); ticks(16);
      chk("R5 prescale", count, 16'(16 >> p));
    end
    psel = 2; do_load(16'h0); ticks(7);
    chk("R5 partial div4", count, 16'h1);
    psel = 1; do_load(16'h0); ticks(1);
    do_load(16'h0); ticks(1);
    chk("R9 load clears prescaler", count, 16'h0);
    psel = 0;
  endtask

  task automatic t_run;
    do_load(16'h0005); run_en = 0; ticks(5);
    chk("R8 disabled", count, 16'h0005);
    run_en = 1;
  endtask

  task automatic t_ext;
    ext_sel = 1; tick_en = 1;
    sync_en = 0; do_load(16'h0); pulse_ext(4);
    chk("R3 async edges", count, 16'h4);
    do_load(16'h0); ext_clk = 1; step(1);
    chk("R3 async edge1", count, 16'h0);
    step(1);
    chk("R3 async edge2", count, 16'h1);
    ext_clk = 0; step(4);
    sync_en = 1; do_load(16'h0); ext_clk = 1; step(2);
    chk("R3 sync edge2", count, 16'h0);
    step(1);
    chk("R3 sync edge3", count, 16'h1);
    ext_clk = 0; step(4);
    do_load(16'h0); pulse_ext(3);
    chk("R3 sync edges", count, 16'h3);
    tick_en = 0; ext_sel = 0; sync_en = 0;
  endtask

  task automatic t_halt;
    core_halt = 1;
    do_load(16'h0); ticks(4);
    chk("R4 halt timer", count, 16'h0);
    ext_sel = 1; sync_en = 1; pulse_ext(2);
    chk("R4 halt sync", count, 16'h0);
    sync_en = 0; pulse_ext(3);
    chk("R4 halt async", count, 16'h3);
    ext_sel = 0; core_halt = 0;
  endtask

  task automatic t_gate;
    gate_en = 1; gate_src = 0; gate_pin = 1;
    do_load(16'h0); ticks(4);
    chk("R6 gate closed", count, 16'h0);
    gate_pin = 0; ticks(4);
    chk("R6 gate open", count, 16'h4);
    gate_en = 0; gate_pin = 1; ticks(2);
    chk("R6 gating off", count, 16'h6);
    gate_pin = 0;
  endtask

  task automatic t_cmp;
    gate_en = 1; gate_src = 1;
    sync_en = 1; cmp_out = 0; do_load(16'h0); step(1);
    tick_en = 1; step(1); cmp_out = 1; step(4); tick_en = 0;
    chk("R7 retimed gate", count, 16'h5);
    step(2);
    ticks(3);
    chk("R7 retimed closed", count, 16'h5);
    sync_en = 0; cmp_out = 0; do_load(16'h0); step(1);
    tick_en = 1; step(1); cmp_out = 1; step(4); tick_en = 0;
    chk("R7 direct gate", count, 16'h1);
    cmp_out = 0; gate_en = 0; gate_src = 0;
  endtask

  task automatic t_ovf;
    do_load(16'hfffe); ticks(2);
    chk("R10 wrap count", count, 16'h0);
    chk("R10 ovf set", {15'b0, ovf}, 16'h1);
    ticks(3);
    chk("R10 sticky", {15'b0, ovf}, 16'h1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk("R10 cleared", {15'b0, ovf}, 16'h0);
    load = 1; load_val = 16'hffff; tick_en = 1; step(1); load = 0; tick_en = 0;
    chk("R9 load over inc", count, 16'hffff);
    chk("R9 no ovf on load", {15'b0, ovf}, 16'h0);
    tick_en = 1; ovf_clr = 1; step(1); tick_en = 0; ovf_clr = 0;
    chk("R10 set beats clear", {15'b0, ovf}, 16'h1);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset; t_timer; t_prescale; t_run; t_ext; t_halt; t_gate; t_cmp; t_ovf;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #200000;
    vectors++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule